// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 64 interrupt request lines, records each one in a pending bit, and picks one winner to hand to a processor core. The core receives a request flag, the 2-bit level of the winner, its vector number and the address it should fetch from.

Each source carries a 2-bit level field set by software. A few sources can be built as non-disableable. Two fast slots can each name one source and give it a complete handler address. A named source then outranks every other request up to level 2.

The core supplies its current 2-bit mask level and pulses an acknowledge with the vector number it has taken. The acknowledge clears that pending bit. A small write/read register bus reaches the level fields, the vector base, the fast slots, the pending bits and a status word.

Top module: `ic_top`

## Requirements
- R1: For an ordinary source the level field decodes as follows: 00 disables the source and is the reset value; 01, 10 and 11 give levels 0, 1 and 2. A disabled source is never presented, even while its pending bit is set.
- R2: Sources flagged in FIXED_MASK are non-disableable (vectors 0 and 1 by default). Their field values 00, 01, 10 and 11 give levels 1, 2, 3 and 3.
- R3: Of the eligible requests, the one with the highest level is presented. Between equal levels, the lower vector number wins.
- R4: A request is presented only if its level is greater than or equal to `core_mask_i`. A mask of 3 therefore passes only level-3 requests.
- R5: A fast slot is enabled by bit 15 of its vector register, and bits [5:0] hold the vector number. While the slot is enabled and that vector is pending, the slot is presented at level 2 with its programmed 23-bit address. It outranks every table request of level 2 or below, but a level-3 request beats it.
- R6: If both fast slots are hit at once, slot 0 is presented.
- R7: For a table winner the address is {vector base, vector number, 1'b0}. The vector base register (offset 8) resets to zero.
- R8: Pending bits are read at offsets 16 to 19, and vector v appears in register 16+v/16 at bit v%16. A pending bit is set in any cycle its request line is high. It is cleared by an acknowledge naming its vector, unless the line is still high.
- R9: The status word (offset 15) holds the following fields. Bit 15 is the request flag. Bits [14:8] are address bits [7:1] captured at the last acknowledge. Bits [1:0] are the presented level.
- R10: Reset leaves no request presented, no pending bit set and every register at zero.

Register map: offsets 0-7 are the level fields, with vector k in register k/8 at bits [2(k%8)+1:2(k%8)]. The fast slots use the following offsets:

| Slot | Vector | Address [15:0] | Address [22:16] |
|------|--------|----------------|-----------------|
| 0    | 9      | 10             | 11              |
| 1    | 12     | 13             | 14              |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from offset |
| irq_i | input | 64 | Request lines, index = vector number |
| core_mask_i | input | 2 | Core's current mask level |
| ack_i | input | 1 | Acknowledge pulse |
| ack_vec_i | input | 6 | Vector being acknowledged |
| irq_req_o | output | 1 | A request is presented |
| irq_level_o | output | 2 | Level of presented request |
| irq_vec_o | output | 6 | Vector number of presented request |
| irq_vaddr_o | output | 23 | Handler address of presented request |

## Verification
The timing is the same for a request line and for a configuration change:

- A request line that rises before clock edge N is captured in its pending bit at edge N.
- The presented outputs change at edge N+1. The bench therefore samples them on the second falling edge after driving a line.
- A register write takes effect at the edge where the strobe is seen, and the outputs follow one edge later.
- An acknowledge clears the pending bit at its own edge. The outputs drop one edge after that.

Register reads are combinational, so they are sampled a moment after the offset is driven.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int ADR_W = 6;

    localparam logic [ADR_W-1:0] OFF_VBASE  = 6'd8;
    localparam logic [ADR_W-1:0] OFF_FAST   = 6'd9;   // slot f: vec at 9+3f, lo at 10+3f, hi at 11+3f
    localparam logic [ADR_W-1:0] OFF_STATUS = 6'd15;
    localparam logic [ADR_W-1:0] OFF_PEND   = 6'd16;

    typedef struct packed {
        logic       on;
        logic [1:0] lvl;
    } lvl_t;

    // Maps a 2-bit field to an effective level; non-disableable sources use the raised map.
    function automatic lvl_t decode_field(input logic [1:0] f, input logic fixed);
        lvl_t r;
        if (fixed) begin
            r.on  = 1'b1;
            r.lvl = (f == 2'b11) ? 2'd3 : f + 2'd1;
        end else begin
            r.on  = (f != 2'b00);
            r.lvl = f - 2'd1;
        end
        return r;
    endfunction
endpackage

// File: rtl/ic_regs.sv
module ic_regs
    import ic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int VEC_W   = 6,
    parameter int VB_W    = 16,
    parameter int VADDR_W = 23
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        bus_we_i,
    input  logic [ADR_W-1:0]            bus_addr_i,
    input  logic [15:0]                 bus_wdata_i,
    output logic [15:0]                 bus_rdata_o,
    input  logic [NUM_SRC-1:0]          irq_i,
    input  logic                        ack_i,
    input  logic [VEC_W-1:0]            ack_vec_i,
    input  logic                        cur_req_i,
    input  logic [1:0]                  cur_level_i,
    input  logic [VADDR_W-1:0]          cur_vaddr_i,
    output logic [2*NUM_SRC-1:0]        prio_o,
    output logic [VB_W-1:0]             vbase_o,
    output logic [1:0]                  fen_o,
    output logic [1:0][VEC_W-1:0]       fvec_o,
    output logic [1:0][VADDR_W-1:0]     faddr_o,
    output logic [NUM_SRC-1:0]          pend_o
);
    localparam int PRIO_REGS = NUM_SRC / 8;
    localparam int PEND_REGS = NUM_SRC / 16;
    localparam int HI_W      = VADDR_W - 16;

    typedef struct packed {
        logic [2*NUM_SRC-1:0]    prio;
        logic [VB_W-1:0]         vbase;
        logic [1:0]              fen;
        logic [1:0][VEC_W-1:0]   fvec;
        logic [1:0][VADDR_W-1:0] faddr;
        logic [NUM_SRC-1:0]      pend;
        logic [6:0]              last;
    } st_t;

    st_t s_d, s_q;
    logic [NUM_SRC-1:0] clr;

    always_comb begin
        s_d = s_q;
        clr = '0;
        if (ack_i) begin
            clr[ack_vec_i] = 1'b1;
            s_d.last       = cur_vaddr_i[7:1];
        end
        s_d.pend = (s_q.pend & ~clr) | irq_i;

        if (bus_we_i) begin
            for (int r = 0; r < PRIO_REGS; r++) begin
                if (bus_addr_i == ADR_W'(r)) s_d.prio[r*16 +: 16] = bus_wdata_i;
            end
            if (bus_addr_i == OFF_VBASE) s_d.vbase = bus_wdata_i[VB_W-1:0];
            for (int f = 0; f < 2; f++) begin
                if (bus_addr_i == OFF_FAST + ADR_W'(3*f)) begin
                    s_d.fvec[f] = bus_wdata_i[VEC_W-1:0];
                    s_d.fen[f]  = bus_wdata_i[15];
                end
                if (bus_addr_i == OFF_FAST + ADR_W'(3*f + 1)) s_d.faddr[f][15:0] = bus_wdata_i;
                if (bus_addr_i == OFF_FAST + ADR_W'(3*f + 2))
                    s_d.faddr[f][VADDR_W-1:16] = bus_wdata_i[HI_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        for (int r = 0; r < PRIO_REGS; r++) begin
            if (bus_addr_i == ADR_W'(r)) bus_rdata_o = s_q.prio[r*16 +: 16];
        end
        if (bus_addr_i == OFF_VBASE) bus_rdata_o = 16'(s_q.vbase);
        for (int f = 0; f < 2; f++) begin
            if (bus_addr_i == OFF_FAST + ADR_W'(3*f))
                bus_rdata_o = {s_q.fen[f], 15'(s_q.fvec[f])};
            if (bus_addr_i == OFF_FAST + ADR_W'(3*f + 1)) bus_rdata_o = s_q.faddr[f][15:0];
            if (bus_addr_i == OFF_FAST + ADR_W'(3*f + 2))
                bus_rdata_o = 16'(s_q.faddr[f][VADDR_W-1:16]);
        end
        if (bus_addr_i == OFF_STATUS) bus_rdata_o = {cur_req_i, s_q.last, 6'b0, cur_level_i};
        for (int r = 0; r < PEND_REGS; r++) begin
            if (bus_addr_i == OFF_PEND + ADR_W'(r)) bus_rdata_o = s_q.pend[r*16 +: 16];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign prio_o  = s_q.prio;
    assign vbase_o = s_q.vbase;
    assign fen_o   = s_q.fen;
    assign fvec_o  = s_q.fvec;
    assign faddr_o = s_q.faddr;
    assign pend_o  = s_q.pend;
endmodule

// File: rtl/ic_arbiter.sv
module ic_arbiter
    import ic_pkg::*;
#(
    parameter int                 NUM_SRC    = 64,
    parameter int                 VEC_W      = 6,
    parameter int                 VB_W       = 16,
    parameter int                 VADDR_W    = 23,
    parameter logic [NUM_SRC-1:0] FIXED_MASK = '0
) (
    input  logic [2*NUM_SRC-1:0]    prio_i,
    input  logic [NUM_SRC-1:0]      pend_i,
    input  logic [VB_W-1:0]         vbase_i,
    input  logic [1:0]              fen_i,
    input  logic [1:0][VEC_W-1:0]   fvec_i,
    input  logic [1:0][VADDR_W-1:0] faddr_i,
    input  logic [1:0]              mask_i,
    output logic                    win_req_o,
    output logic [1:0]              win_lvl_o,
    output logic [VEC_W-1:0]        win_vec_o,
    output logic [VADDR_W-1:0]      win_vaddr_o
);
    logic             tbl_v;
    logic [1:0]       tbl_lvl;
    logic [VEC_W-1:0] tbl_vec;
    logic [1:0]       fast_hit;
    lvl_t             dec;

    // Scan from the top vector down so that an equal level at a lower vector replaces the holder.
    always_comb begin
        tbl_v   = 1'b0;
        tbl_lvl = '0;
        tbl_vec = '0;
        dec     = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            dec = decode_field(prio_i[2*i +: 2], FIXED_MASK[i]);
            if (pend_i[i] && dec.on && (!tbl_v || dec.lvl >= tbl_lvl)) begin
                tbl_v   = 1'b1;
                tbl_lvl = dec.lvl;
                tbl_vec = VEC_W'(i);
            end
        end
    end

    generate
        for (genvar f = 0; f < 2; f++) begin : g_fast
            assign fast_hit[f] = fen_i[f] && pend_i[fvec_i[f]] && (mask_i <= 2'd2);
        end
    endgenerate

    always_comb begin
        win_req_o   = 1'b0;
        win_lvl_o   = '0;
        win_vec_o   = '0;
        win_vaddr_o = '0;
        if (tbl_v && tbl_lvl == 2'd3) begin
            win_req_o   = 1'b1;
            win_lvl_o   = tbl_lvl;
            win_vec_o   = tbl_vec;
            win_vaddr_o = {vbase_i, tbl_vec, 1'b0};
        end else if (fast_hit[0]) begin
            win_req_o   = 1'b1;
            win_lvl_o   = 2'd2;
            win_vec_o   = fvec_i[0];
            win_vaddr_o = faddr_i[0];
        end else if (fast_hit[1]) begin
            win_req_o   = 1'b1;
            win_lvl_o   = 2'd2;
            win_vec_o   = fvec_i[1];
            win_vaddr_o = faddr_i[1];
        end else if (tbl_v && tbl_lvl >= mask_i) begin
            win_req_o   = 1'b1;
            win_lvl_o   = tbl_lvl;
            win_vec_o   = tbl_vec;
            win_vaddr_o = {vbase_i, tbl_vec, 1'b0};
        end
    end
endmodule

// File: rtl/ic_top.sv
module ic_top
    import ic_pkg::*;
#(
    parameter int                 NUM_SRC    = 64,
    parameter logic [NUM_SRC-1:0] FIXED_MASK = NUM_SRC'(3),
    parameter int                 VB_W       = 16,
    localparam int                VEC_W      = $clog2(NUM_SRC),
    localparam int                VADDR_W    = VB_W + VEC_W + 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               bus_we_i,
    input  logic [5:0]         bus_addr_i,
    input  logic [15:0]        bus_wdata_i,
    output logic [15:0]        bus_rdata_o,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic [1:0]         core_mask_i,
    input  logic               ack_i,
    input  logic [VEC_W-1:0]   ack_vec_i,
    output logic               irq_req_o,
    output logic [1:0]         irq_level_o,
    output logic [VEC_W-1:0]   irq_vec_o,
    output logic [VADDR_W-1:0] irq_vaddr_o
);
    typedef struct packed {
        logic               req;
        logic [1:0]         lvl;
        logic [VEC_W-1:0]   vec;
        logic [VADDR_W-1:0] vaddr;
    } out_t;

    out_t o_d, o_q;

    logic [2*NUM_SRC-1:0]    prio_w;
    logic [VB_W-1:0]         vbase_w;
    logic [1:0]              fen_w;
    logic [1:0][VEC_W-1:0]   fvec_w;
    logic [1:0][VADDR_W-1:0] faddr_w;
    logic [NUM_SRC-1:0]      pend_w;
    logic                    win_req;
    logic [1:0]              win_lvl;
    logic [VEC_W-1:0]        win_vec;
    logic [VADDR_W-1:0]      win_vaddr;

    ic_regs #(
        .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VB_W(VB_W), .VADDR_W(VADDR_W)
    ) regs_i (
        .clk_i(clk_i), .rst_i(rst_i),
        .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o),
        .irq_i(irq_i), .ack_i(ack_i), .ack_vec_i(ack_vec_i),
        .cur_req_i(o_q.req), .cur_level_i(o_q.lvl), .cur_vaddr_i(o_q.vaddr),
        .prio_o(prio_w), .vbase_o(vbase_w), .fen_o(fen_w), .fvec_o(fvec_w),
        .faddr_o(faddr_w), .pend_o(pend_w)
    );

    ic_arbiter #(
        .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VB_W(VB_W), .VADDR_W(VADDR_W),
        .FIXED_MASK(FIXED_MASK)
    ) arb_i (
        .prio_i(prio_w), .pend_i(pend_w), .vbase_i(vbase_w), .fen_i(fen_w),
        .fvec_i(fvec_w), .faddr_i(faddr_w), .mask_i(core_mask_i),
        .win_req_o(win_req), .win_lvl_o(win_lvl), .win_vec_o(win_vec),
        .win_vaddr_o(win_vaddr)
    );

    always_comb begin
        o_d.req   = win_req;
        o_d.lvl   = win_lvl;
        o_d.vec   = win_vec;
        o_d.vaddr = win_vaddr;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) o_q <= '0;
        else       o_q <= o_d;
    end

    assign irq_req_o   = o_q.req;
    assign irq_level_o = o_q.lvl;
    assign irq_vec_o   = o_q.vec;
    assign irq_vaddr_o = o_q.vaddr;
endmodule

// File: rtl/ic_chk.sv
module ic_chk #(
    parameter int NUM_SRC = 64,
    parameter int VEC_W   = 6
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] irq,
    input logic [NUM_SRC-1:0] pend,
    input logic               ack,
    input logic [VEC_W-1:0]   ack_vec,
    input logic [1:0]         mask,
    input logic               req,
    input logic [1:0]         lvl
);
    assert_mask_R4: assert property (@(posedge clk) disable iff (rst)
        req |-> (lvl >= $past(mask)));

    assert_pend_set_R8: assert property (@(posedge clk) disable iff (rst)
        (irq != '0) |=> ((pend & $past(irq)) == $past(irq)));

    assert_ack_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (ack && !irq[ack_vec]) |=> !pend[$past(ack_vec)]);

    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (!req && pend == '0));
endmodule

bind ic_top ic_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) chk_i (
    .clk(clk_i), .rst(rst_i), .irq(irq_i), .pend(pend_w), .ack(ack_i),
    .ack_vec(ack_vec_i), .mask(core_mask_i), .req(irq_req_o), .lvl(irq_level_o)
);

// File: tb/ic_top_tb_top.sv
module ic_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [63:0] irq = '0;
    logic [1:0]  mask = '0;
    logic        ack = 1'b0;
    logic [5:0]  ack_vec = '0;
    logic        req;
    logic [1:0]  lvl;
    logic [5:0]  vec;
    logic [22:0] vaddr;

    int checks = 0;
    int fails  = 0;
    logic [15:0] prio_sh [8];
    logic [15:0] rv;

    always #4 clk = ~clk;

    ic_top dut_i (
        .clk_i(clk), .rst_i(rst), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_i(irq),
        .core_mask_i(mask), .ack_i(ack), .ack_vec_i(ack_vec),
        .irq_req_o(req), .irq_level_o(lvl), .irq_vec_o(vec), .irq_vaddr_o(vaddr)
    );

    // a(6) fa(2) b(6) fb(2) mask(2) exp_req(1) exp_vec(6) exp_lvl(2)
    localparam logic [26:0] TBL [11] = '{
        {6'd10, 2'b01, 6'd20, 2'b00, 2'd0, 1'b1, 6'd10, 2'd0},
        {6'd10, 2'b01, 6'd20, 2'b10, 2'd0, 1'b1, 6'd20, 2'd1},
        {6'd30, 2'b11, 6'd5,  2'b11, 2'd0, 1'b1, 6'd5,  2'd2},
        {6'd30, 2'b10, 6'd40, 2'b10, 2'd1, 1'b1, 6'd30, 2'd1},
        {6'd30, 2'b10, 6'd40, 2'b01, 2'd2, 1'b0, 6'd0,  2'd0},
        {6'd0,  2'b00, 6'd63, 2'b11, 2'd0, 1'b1, 6'd63, 2'd2},
        {6'd1,  2'b10, 6'd63, 2'b11, 2'd3, 1'b1, 6'd1,  2'd3},
        {6'd0,  2'b11, 6'd1,  2'b11, 2'd3, 1'b1, 6'd0,  2'd3},
        {6'd0,  2'b01, 6'd2,  2'b11, 2'd2, 1'b1, 6'd0,  2'd2},
        {6'd50, 2'b00, 6'd51, 2'b00, 2'd0, 1'b0, 6'd0,  2'd0},
        {6'd1,  2'b00, 6'd62, 2'b00, 2'd1, 1'b1, 6'd1,  2'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_prio(input int k, input logic [1:0] f);
        prio_sh[k/8][2*(k%8) +: 2] = f;
        bus_write(6'(k/8), prio_sh[k/8]);
    endtask

    task automatic do_ack(input logic [5:0] v);
        ack = 1'b1; ack_vec = v;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) prio_sh[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state
        chk("R10 req after reset", 32'(req), 32'd0);
        bus_read(6'd8, rv);  chk("R7 vector base reset", 32'(rv), 32'd0);
        bus_read(6'd15, rv); chk("R10 status reset", 32'(rv), 32'd0);
        bus_read(6'd16, rv); chk("R10 pending reset", 32'(rv), 32'd0);
        @(negedge clk);

        // Pending tracking: one-cycle pulse on disabled source 17
        irq[17] = 1'b1; @(negedge clk); irq[17] = 1'b0;
        @(negedge clk);
        bus_read(6'd17, rv); chk("R8 pulse latched in pending", 32'(rv), 32'h2);
        chk("R1 disabled source not presented", 32'(req), 32'd0);
        do_ack(6'd17);
        bus_read(6'd17, rv); chk("R8 ack clears pending", 32'(rv), 32'h0);
        irq[33] = 1'b1; @(negedge clk);
        do_ack(6'd33);
        bus_read(6'd18, rv); chk("R8 held line re-sets pending", 32'(rv), 32'h2);
        irq[33] = 1'b0; @(negedge clk);
        do_ack(6'd33);
        bus_read(6'd18, rv); chk("R8 cleared after release", 32'(rv), 32'h0);

        bus_write(6'd8, 16'h0123);

        // Table of arbitration cases
        for (int i = 0; i < 11; i++) begin
            logic [5:0] a, b, ev;
            logic [1:0] fa, fb, m, el;
            logic er;
            {a, fa, b, fb, m, er, ev, el} = TBL[i];
            set_prio(int'(a), fa);
            set_prio(int'(b), fb);
            mask = m;
            irq[a] = 1'b1; irq[b] = 1'b1;
            @(negedge clk); @(negedge clk);
            chk($sformatf("R1 R2 R3 R4 row %0d req", i), 32'(req), 32'(er));
            if (er) begin
                chk($sformatf("R3 row %0d vector", i), 32'(vec), 32'(ev));
                chk($sformatf("R2 R3 row %0d level", i), 32'(lvl), 32'(el));
                chk($sformatf("R7 row %0d address", i), 32'(vaddr), 32'({16'h0123, ev, 1'b0}));
            end
            irq = '0;
            do_ack(a);
            do_ack(b);
            set_prio(int'(a), 2'b00);
            set_prio(int'(b), 2'b00);
            mask = 2'd0;
            @(negedge clk);
        end

        // Fast slots
        set_prio(12, 2'b01);
        set_prio(40, 2'b11);
        bus_write(6'd10, 16'h4321);
        bus_write(6'd11, 16'h0005);
        bus_write(6'd9, 16'h8000 | 16'd12);
        irq[12] = 1'b1; irq[40] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R5 fast slot outranks level 2 vector", 32'(vec), 32'd12);
        chk("R5 fast slot level", 32'(lvl), 32'd2);
        chk("R5 fast slot address", 32'(vaddr), 32'h054321);
        bus_write(6'd13, 16'h1111);
        bus_write(6'd14, 16'h0022);
        bus_write(6'd12, 16'h8000 | 16'd40);
        @(negedge clk);
        chk("R6 slot 0 beats slot 1", 32'(vec), 32'd12);
        bus_write(6'd9, 16'd12);
        @(negedge clk);
        chk("R5 slot 1 alone vector", 32'(vec), 32'd40);
        chk("R5 slot 1 alone address", 32'(vaddr), 32'h221111);
        set_prio(1, 2'b10);
        irq[1] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R5 level 3 beats fast vector", 32'(vec), 32'd1);
        chk("R2 R5 level 3 beats fast level", 32'(lvl), 32'd3);

        // Status word: capture address bits on acknowledge
        irq[1] = 1'b0;
        @(negedge clk);
        do_ack(6'd1);
        @(negedge clk); @(negedge clk);
        bus_read(6'd15, rv);
        chk("R9 status word", 32'(rv), 32'hC102);

        irq = '0;
        @(negedge clk);
        summary();
        $finish;
    end
endmodule